// File: doc/BRIEF.md
# Debug Serial Command Receiver

This block is the front end of a serial debug port. A host sends 8N1 frames on an asynchronous receive pin. The block first brings that pin into the system clock domain. It then finds the bit period, either by timing a known synchronisation character sent by the host or from a divider fixed at build time. Each received byte is mid-bit sampled and fed into a small command assembler. The assembler turns a command byte, plus any data bytes that follow it, into a one-cycle command strobe carrying a write flag, a width flag, a 6-bit register address and up to 16 bits of write data.

Read responses go back to the host through a matching transmitter. It sends one or two 8N1 frames, low byte first, at the same bit period that the receiver uses. The debug register file, memory sequencing and processor halt logic sit outside this block. They consume the strobe and supply the response data.

Top module: `dbg_uart_cmd_rx`

## Requirements
- R1: Frames are 8N1 with the least significant bit first. Each data bit is sampled once, near the middle of its bit time.
- R2: With AUTO_SYNC=1, the first frame after reset must be the character 0x80. The bit period is the number of clocks the line stays low during that character (start bit plus seven zero bits), divided by 8. This frame produces no command strobe and no framing error.
- R3: With AUTO_SYNC=0, every bit lasts CLK_HZ/BAUD clocks, which means the bit counter reloads with CLK_HZ/BAUD-1. No synchronisation character is expected.
- R4: A low pulse that has ended by the middle of the start bit is ignored. It produces no byte, no strobe and no framing error, and the next valid frame is received normally.
- R5: A frame whose stop bit is sampled low pulses `frame_err_o` for exactly one cycle. The byte is discarded, and the command assembler keeps its state as if that frame had never arrived.
- R6: Command byte fields: bit 7 is the write flag (1 = write), bit 6 is the width flag (1 = byte, 0 = word), and bits 5:0 are the register address. These appear on `cmd_wr_o`, `cmd_byte_o` and `cmd_addr_o` together with the strobe.
- R7: A read command (bit 7 = 0) raises `cmd_vld_o` for one cycle right after its command byte, with `cmd_data_o` = 0.
- R8: A word write waits for two data bytes, low byte first. It issues no strobe after the first data byte, and issues the strobe after the second with `cmd_data_o` = {second, first}.
- R9: A byte write waits for one data byte and then issues the strobe with `cmd_data_o` = {8'h00, byte}.
- R10: A pulse on `tx_start_i` while `tx_busy_o` is low sends `tx_data_i[7:0]`, followed by `tx_data_i[15:8]` unless `tx_byte_i` is set, as 8N1 frames at the current bit period. `tx_busy_o` is high during sending, and `txd_o` is high when idle.
- R11: After reset, `cmd_vld_o`, `frame_err_o` and `tx_busy_o` are low and `txd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial receive line |
| cmd_vld_o | output | 1 | One-cycle command strobe |
| cmd_wr_o | output | 1 | Write flag of the command |
| cmd_byte_o | output | 1 | Width flag, 1 = byte access |
| cmd_addr_o | output | 6 | Debug register address |
| cmd_data_o | output | 16 | Write data (0 for reads) |
| frame_err_o | output | 1 | One-cycle framing error pulse |
| tx_start_i | input | 1 | Start a response transmission |
| tx_byte_i | input | 1 | 1 = send one byte, 0 = send two |
| tx_data_i | input | 16 | Response data |
| txd_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | Transmitter active |

## Verification
The receiver is driven with each command shape: reads, byte writes and word writes, using both directed and randomly drawn addresses and data. This separates errors in field placement, in byte ordering and in how many data bytes are awaited. A short low glitch and a frame with a low stop bit, one of them inserted in the middle of a word write, show whether the receiver can tell noise and bad frames apart from real bytes without upsetting the assembler. A second instance built with a fixed divider, together with transmitted byte and word responses, checks that the learned period and the fixed period both give correct bit timing.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
  typedef enum logic [2:0] {
    RX_SYNC_WAIT, RX_SYNC_MEAS, RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
  } rx_state_e;

  typedef enum logic [1:0] {CM_CMD, CM_LO, CM_HI} cm_state_e;

  localparam int CMD_WR_BIT   = 7;
  localparam int CMD_BYTE_BIT = 6;
  localparam int ADDR_W       = 6;
  localparam int DATA_W       = 16;
endpackage

// File: rtl/dbg_uart_rx_core.sv
module dbg_uart_rx_core
  import dbg_uart_pkg::*;
#(
  parameter int             CNT_W     = 16,
  parameter bit             AUTO_SYNC = 1'b1,
  parameter int             SYNC_LOW  = 8,
  parameter logic [CNT_W-1:0] FIXED_DIV = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic [CNT_W-1:0] div_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             frame_err_o
);
  localparam int SHIFT = $clog2(SYNC_LOW);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt, div;
  logic [2:0]       bit_idx;
  logic [7:0]       sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= AUTO_SYNC ? RX_SYNC_WAIT : RX_IDLE;
      div         <= AUTO_SYNC ? '0 : FIXED_DIV;
      cnt         <= '0;
      bit_idx     <= '0;
      sh          <= '0;
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      byte_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      case (state)
        RX_SYNC_WAIT: if (!rx_i) begin cnt <= ONE; state <= RX_SYNC_MEAS; end
        RX_SYNC_MEAS: begin
          if (rx_i) begin
            div   <= (cnt >> SHIFT) - ONE;  // low clocks / low bit times
            state <= RX_IDLE;
          end else if (cnt != '1) cnt <= cnt + ONE;
        end
        RX_IDLE: if (!rx_i) begin cnt <= div >> 1; state <= RX_START; end
        RX_START: begin
          if (cnt == '0) begin
            if (rx_i) state <= RX_IDLE;  // glitch
            else begin cnt <= div; bit_idx <= '0; state <= RX_DATA; end
          end else cnt <= cnt - ONE;
        end
        RX_DATA: begin
          if (cnt == '0) begin
            sh  <= {rx_i, sh[7:1]};
            cnt <= div;
            if (bit_idx == 3'd7) state <= RX_STOP;
            else bit_idx <= bit_idx + 3'd1;
          end else cnt <= cnt - ONE;
        end
        RX_STOP: begin
          if (cnt == '0) begin
            if (rx_i) begin byte_vld_o <= 1'b1; state <= RX_IDLE; end
            else begin frame_err_o <= 1'b1; state <= RX_WAIT_HIGH; end
          end else cnt <= cnt - ONE;
        end
        RX_WAIT_HIGH: if (rx_i) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign div_o  = div;
  assign byte_o = sh;

  assert_div_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != RX_SYNC_WAIT && state != RX_SYNC_MEAS && $past(state) != RX_SYNC_MEAS)
      |-> $stable(div));
  assert_fixed_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !AUTO_SYNC |-> div == FIXED_DIV);
  assert_glitch_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == RX_START && cnt == '0 && rx_i) |=> (state == RX_IDLE && !byte_vld_o));
  assert_ferr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
endmodule

// File: rtl/dbg_uart_cmd_asm.sv
module dbg_uart_cmd_asm
  import dbg_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  output logic              cmd_vld_o,
  output logic              cmd_wr_o,
  output logic              cmd_byte_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  cm_state_e  state;
  logic [7:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= CM_CMD;
      cmd_q      <= '0;
      cmd_data_o <= '0;
      cmd_vld_o  <= 1'b0;
    end else begin
      cmd_vld_o <= 1'b0;
      if (byte_vld_i) begin
        case (state)
          CM_CMD: begin
            cmd_q <= byte_i;
            if (!byte_i[CMD_WR_BIT]) begin
              cmd_data_o <= '0;
              cmd_vld_o  <= 1'b1;
            end else state <= CM_LO;
          end
          CM_LO: begin
            if (cmd_q[CMD_BYTE_BIT]) begin
              cmd_data_o <= {8'h00, byte_i};
              cmd_vld_o  <= 1'b1;
              state      <= CM_CMD;
            end else begin
              cmd_data_o[7:0] <= byte_i;
              state           <= CM_HI;
            end
          end
          CM_HI: begin
            cmd_data_o[15:8] <= byte_i;
            cmd_vld_o        <= 1'b1;
            state            <= CM_CMD;
          end
          default: state <= CM_CMD;
        endcase
      end
    end
  end

  assign cmd_wr_o   = cmd_q[CMD_WR_BIT];
  assign cmd_byte_o = cmd_q[CMD_BYTE_BIT];
  assign cmd_addr_o = cmd_q[ADDR_W-1:0];

  assert_strobe_follows_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> $past(byte_vld_i));
  assert_read_no_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && !cmd_wr_o) |-> cmd_data_o == '0);
  assert_byte_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_o && cmd_wr_o && cmd_byte_o) |-> cmd_data_o[15:8] == 8'h00);
endmodule

// File: rtl/dbg_uart_tx_core.sv
module dbg_uart_tx_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_i,
  input  logic             start_i,
  input  logic             byte_i,
  input  logic [15:0]      data_i,
  output logic             txd_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [19:0]      sh;
  logic [4:0]       bits_left;
  logic [CNT_W-1:0] cnt;

  assign busy_o = (bits_left != 5'd0);
  assign txd_o  = busy_o ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh        <= '1;
      bits_left <= '0;
      cnt       <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        sh        <= byte_i ? {10'h3FF, 1'b1, data_i[7:0], 1'b0}
                            : {1'b1, data_i[15:8], 1'b0, 1'b1, data_i[7:0], 1'b0};
        bits_left <= byte_i ? 5'd10 : 5'd20;
        cnt       <= div_i;
      end
    end else if (cnt == '0) begin
      sh        <= {1'b1, sh[19:1]};
      bits_left <= bits_left - 5'd1;
      cnt       <= div_i;
    end else cnt <= cnt - ONE;
  end

  assert_start_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !txd_o));
endmodule

// File: rtl/dbg_uart_cmd_rx.sv
module dbg_uart_cmd_rx
  import dbg_uart_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 6_250_000,
  parameter bit AUTO_SYNC = 1'b1,
  parameter bit SYNC_EN   = 1'b1,
  parameter int CNT_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rxd_i,
  output logic        cmd_vld_o,
  output logic        cmd_wr_o,
  output logic        cmd_byte_o,
  output logic [5:0]  cmd_addr_o,
  output logic [15:0] cmd_data_o,
  output logic        frame_err_o,
  input  logic        tx_start_i,
  input  logic        tx_byte_i,
  input  logic [15:0] tx_data_i,
  output logic        txd_o,
  output logic        tx_busy_o
);
  localparam logic [CNT_W-1:0] FIXED_DIV = CNT_W'(CLK_HZ / BAUD - 1);

  logic             rx_s, byte_vld;
  logic [7:0]       rx_byte;
  logic [CNT_W-1:0] div;

  generate
    if (SYNC_EN) begin : g_sync
      logic [1:0] ff;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff <= 2'b11;
        else         ff <= {ff[0], rxd_i};
      end
      assign rx_s = ff[1];
    end else begin : g_nosync
      assign rx_s = rxd_i;
    end
  endgenerate

  dbg_uart_rx_core #(.CNT_W(CNT_W), .AUTO_SYNC(AUTO_SYNC), .SYNC_LOW(8),
                     .FIXED_DIV(FIXED_DIV)) u_rx (
    .clk_i, .rst_ni, .rx_i(rx_s), .div_o(div), .byte_o(rx_byte),
    .byte_vld_o(byte_vld), .frame_err_o(frame_err_o));

  dbg_uart_cmd_asm u_asm (
    .clk_i, .rst_ni, .byte_i(rx_byte), .byte_vld_i(byte_vld),
    .cmd_vld_o, .cmd_wr_o, .cmd_byte_o, .cmd_addr_o, .cmd_data_o);

  dbg_uart_tx_core #(.CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .div_i(div), .start_i(tx_start_i), .byte_i(tx_byte_i),
    .data_i(tx_data_i), .txd_o(txd_o), .busy_o(tx_busy_o));
endmodule

// File: tb/sim_dbg_uart_cmd_rx.sv
`timescale 1ns/1ps
module sim_dbg_uart_cmd_rx;
  localparam int BIT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd0 = 1'b1, rxd1 = 1'b1;
  logic tx_start = 1'b0, tx_byte = 1'b0;
  logic [15:0] tx_data = '0;

  logic c_vld0, c_wr0, c_by0, ferr0, txd0, busy0;
  logic [5:0] c_ad0;  logic [15:0] c_dt0;
  logic c_vld1, c_wr1, c_by1, ferr1, txd1, busy1;
  logic [5:0] c_ad1;  logic [15:0] c_dt1;

  int checks = 0, fails = 0;
  int n_cmd0 = 0, n_ferr0 = 0, n_cmd1 = 0;
  logic l_wr0, l_by0, l_wr1; logic [5:0] l_ad0, l_ad1; logic [15:0] l_dt0;

  always #5 clk = ~clk;

  dbg_uart_cmd_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd0), .cmd_vld_o(c_vld0), .cmd_wr_o(c_wr0),
    .cmd_byte_o(c_by0), .cmd_addr_o(c_ad0), .cmd_data_o(c_dt0), .frame_err_o(ferr0),
    .tx_start_i(tx_start), .tx_byte_i(tx_byte), .tx_data_i(tx_data),
    .txd_o(txd0), .tx_busy_o(busy0));

  dbg_uart_cmd_rx #(.AUTO_SYNC(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd1), .cmd_vld_o(c_vld1), .cmd_wr_o(c_wr1),
    .cmd_byte_o(c_by1), .cmd_addr_o(c_ad1), .cmd_data_o(c_dt1), .frame_err_o(ferr1),
    .tx_start_i(1'b0), .tx_byte_i(1'b0), .tx_data_i(16'h0),
    .txd_o(txd1), .tx_busy_o(busy1));

  always @(negedge clk) begin
    if (c_vld0) begin n_cmd0++; l_wr0 = c_wr0; l_by0 = c_by0; l_ad0 = c_ad0; l_dt0 = c_dt0; end
    if (ferr0) n_ferr0++;
    if (c_vld1) begin n_cmd1++; l_wr1 = c_wr1; l_ad1 = c_ad1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int line, input logic v);
    if (line == 0) rxd0 = v; else rxd1 = v;
  endtask

  task automatic send(input int line, input logic [7:0] b, input bit stop_ok = 1'b1);
    drive(line, 1'b0); repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin drive(line, b[i]); repeat (BIT) @(negedge clk); end
    drive(line, stop_ok); repeat (BIT) @(negedge clk);
    drive(line, 1'b1); repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic check_cmd(input string req, input int n_before, input bit wr, input bit by,
                           input logic [5:0] ad, input logic [15:0] dt);
    chk(n_cmd0 == n_before + 1, {req, " strobe count"}, n_cmd0, n_before + 1);
    chk(l_wr0 == wr && l_by0 == by && l_ad0 == ad, {req, " fields R6"},
        {l_wr0, l_by0, l_ad0}, {wr, by, ad});
    chk(l_dt0 == dt, {req, " data"}, l_dt0, dt);
  endtask

  task automatic recv_tx(output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1'b1;
    while (txd0 && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) ok = 1'b0;
    repeat (BIT / 2) @(negedge clk);
    if (txd0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); b[i] = txd0; end
    repeat (BIT) @(negedge clk);
    if (!txd0) ok = 1'b0;
  endtask

  task automatic tx_check(input logic [15:0] d, input bit byte_only);
    logic [7:0] r; bit ok;
    @(negedge clk); tx_data = d; tx_byte = byte_only; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    chk(busy0 == 1'b1, "R10 busy after start", busy0, 1);
    recv_tx(r, ok);
    chk(ok && r == d[7:0], "R10 low byte", r, d[7:0]);
    if (!byte_only) begin
      recv_tx(r, ok);
      chk(ok && r == d[15:8], "R10 high byte", r, d[15:8]);
    end
    repeat (BIT) @(negedge clk);
    chk(!busy0 && txd0, "R10 idle after send", {busy0, txd0}, 2'b01);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, nf;
    logic [7:0] lo, hi; logic [5:0] ad;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(!c_vld0 && !ferr0 && !busy0 && txd0, "R11 reset state",
        {c_vld0, ferr0, busy0, txd0}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: sync character
    send(0, 8'h80);
    chk(n_cmd0 == 0 && n_ferr0 == 0, "R2 sync frame silent", n_cmd0 + n_ferr0, 0);

    // R7 read, R1 bit order
    n = n_cmd0; send(0, 8'h2A);
    check_cmd("R7 read", n, 1'b0, 1'b0, 6'h2A, 16'h0);

    // R8 word write
    n = n_cmd0; send(0, 8'h85); send(0, 8'h34);
    chk(n_cmd0 == n, "R8 no strobe after first data byte", n_cmd0, n);
    send(0, 8'h12);
    check_cmd("R8 word write", n, 1'b1, 1'b0, 6'h05, 16'h1234);

    // R9 byte write
    n = n_cmd0; send(0, 8'hC9); send(0, 8'hAB);
    check_cmd("R9 byte write", n, 1'b1, 1'b1, 6'h09, 16'h00AB);

    // R4 glitch
    n = n_cmd0; nf = n_ferr0;
    rxd0 = 1'b0; repeat (3) @(negedge clk); rxd0 = 1'b1; repeat (3 * BIT) @(negedge clk);
    chk(n_cmd0 == n && n_ferr0 == nf, "R4 glitch ignored", n_cmd0 - n + n_ferr0 - nf, 0);
    send(0, 8'h11);
    check_cmd("R4 read after glitch", n, 1'b0, 1'b0, 6'h11, 16'h0);

    // R5 framing error, alone and inside a word write
    n = n_cmd0; nf = n_ferr0;
    send(0, 8'h55, 1'b0);
    chk(n_ferr0 == nf + 1 && n_cmd0 == n, "R5 single error pulse", n_ferr0 - nf, 1);
    send(0, 8'h81); send(0, 8'h77, 1'b0); send(0, 8'h22); send(0, 8'h33);
    chk(n_ferr0 == nf + 2, "R5 second error", n_ferr0 - nf, 2);
    check_cmd("R5 word write ignores bad frame", n, 1'b1, 1'b0, 6'h01, 16'h3322);

    // random commands: R6 R7 R8 R9
    for (int k = 0; k < 16; k++) begin
      int kind = $urandom % 3;
      ad = 6'($urandom); lo = 8'($urandom); hi = 8'($urandom);
      n = n_cmd0;
      case (kind)
        0: begin send(0, {2'b00, ad}); check_cmd("R7 random read", n, 1'b0, 1'b0, ad, 16'h0); end
        1: begin send(0, {2'b11, ad}); send(0, lo);
                 check_cmd("R9 random byte write", n, 1'b1, 1'b1, ad, {8'h00, lo}); end
        default: begin send(0, {2'b10, ad}); send(0, lo); send(0, hi);
                 check_cmd("R8 random word write", n, 1'b1, 1'b0, ad, {hi, lo}); end
      endcase
    end

    // R3 fixed divider instance
    send(1, 8'h3F);
    chk(n_cmd1 == 1 && l_wr1 == 1'b0 && l_ad1 == 6'h3F, "R3 fixed divider read",
        {n_cmd1[3:0], l_ad1}, {4'd1, 6'h3F});

    // R10 transmit
    tx_check(16'h00A5, 1'b1);
    tx_check(16'hBEEF, 1'b0);
    for (int k = 0; k < 3; k++) tx_check(16'($urandom), 1'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule